// File: doc/BRIEF.md
# Masked Dual Alarm Comparator

This block watches the live calendar time and raises a flag when it reaches either of two programmed alarm moments. The time arrives as seven BCD bytes: second, minute, hour, date, month, year and weekday. Each alarm holds a value for every one of those bytes and one enable bit per byte. Only the bytes whose enable bit is set take part in the comparison. The other bytes are wildcards, so one comparator gives weekly alarms (weekday, hour and minute enabled), daily alarms (hour and minute) or yearly ones (month added to the others).

Matching is evaluated only on the once-per-second update strobe. An alarm's flag sets on the update where that alarm goes from no match to match. The flag then stays set until software clears it through a small status-write port. Software learns of an alarm only by polling the flags.

Top module: `alarm_match_top`

## Requirements
- R1: After reset both bits of `alarmFlag` read 0.
- R2: An alarm matches when every byte whose enable bit is 1 equals the same byte of `timeNow`. Bytes whose enable bit is 0 have no effect. Byte k sits at bits [8k+7:8k] of `timeNow` and `alarmNVal`, and enable bit k belongs to it: k=0 second, 1 minute, 2 hour, 3 date, 4 month, 5 year, 6 weekday.
- R3: Bit 7 of the hour byte (the clock's 24-hour mode bit) is excluded from the comparison, in both the time and the alarm value.
- R4: An alarm whose enable bits are all 0 never sets its flag.
- R5: Matching is evaluated only in cycles where `tick` is 1. A match present while `tick` is 0 changes no flag.
- R6: On a `tick` where an alarm goes from no match (as of its previous tick) to match, its flag is 1 after that clock edge. The flag stays 1 across later ticks and while the match persists. A match that continues after a clear does not set the flag again.
- R7: With `clrWe`=1, a 1 in `clrMask[i]` clears `alarmFlag[i]` at that edge. A 0 in `clrMask[i]` leaves the flag unchanged.
- R8: If a clear and a new match of the same alarm fall in the same cycle, the flag is 1 afterwards: the new event wins.
- R9: The two alarms are independent. A match or clear of one never changes the other's flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | active-low synchronous reset |
| tick | input | 1 | once-per-second time update strobe |
| timeNow | input | 56 | current time, seven BCD bytes |
| alarm0Val | input | 56 | alarm 0 byte values |
| alarm0En | input | 7 | alarm 0 per-byte enables |
| alarm1Val | input | 56 | alarm 1 byte values |
| alarm1En | input | 7 | alarm 1 per-byte enables |
| clrWe | input | 1 | status write strobe |
| clrMask | input | 2 | write-one-to-clear mask per alarm |
| alarmFlag | output | 2 | sticky alarm flags |

## Verification
Directed cases cover four enable patterns: daily, weekly, yearly and empty. They separate correct wildcarding from a comparator that checks every byte or ignores the enables. A time whose hour bit 7 differs from the alarm tells apart a design that masks the mode bit from one that compares it. Holding a match across several ticks, with clears in between, shows the difference between edge-triggered and level-triggered setting, and clear and match in the same cycle shows which one takes priority. Random stimulus draws every byte from a narrow value range so that matches occur often, with random enables and clears, against a reference model of the requirements.

// File: rtl/alarm_match_pkg.sv
package alarm_match_pkg;
  parameter int NUM_ALARMS = 2;
  parameter int NUM_FIELDS = 7;
  parameter int FIELD_W    = 8;
  parameter int HOUR_IDX   = 2;
  localparam int TIME_W    = NUM_FIELDS * FIELD_W;

  // strobes from control to datapath
  typedef struct packed {
    logic                  capture;
    logic [NUM_ALARMS-1:0] setFlag;
    logic [NUM_ALARMS-1:0] clrFlag;
  } strobe_t;

  // bits of a byte that take part in comparison
  function automatic logic [FIELD_W-1:0] fieldMask(input int idx);
    logic [FIELD_W-1:0] m;
    m = '1;
    if (idx == HOUR_IDX) m[FIELD_W-1] = 1'b0;
    return m;
  endfunction
endpackage

// File: rtl/alarm_match_dp.sv
module alarm_match_dp
  import alarm_match_pkg::*;
(
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic [TIME_W-1:0]                    timeNow,
  input  logic [NUM_ALARMS-1:0][TIME_W-1:0]    alarmVal,
  input  logic [NUM_ALARMS-1:0][NUM_FIELDS-1:0] alarmEn,
  input  strobe_t                              strobes,
  output logic [NUM_ALARMS-1:0]                enterMatch,
  output logic [NUM_ALARMS-1:0]                flags
);
  logic [NUM_ALARMS-1:0] matchNow;
  logic [NUM_ALARMS-1:0] prevMatch;

  for (genvar a = 0; a < NUM_ALARMS; a++) begin : gAlarm
    logic [NUM_FIELDS-1:0] fieldOk;
    for (genvar f = 0; f < NUM_FIELDS; f++) begin : gField
      localparam logic [FIELD_W-1:0] MASK = fieldMask(f);
      assign fieldOk[f] = !alarmEn[a][f] ||
        ((timeNow[f*FIELD_W +: FIELD_W] & MASK) ==
         (alarmVal[a][f*FIELD_W +: FIELD_W] & MASK));
    end
    assign matchNow[a]   = (|alarmEn[a]) && (&fieldOk);
    assign enterMatch[a] = matchNow[a] && !prevMatch[a];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevMatch <= '0;
      flags     <= '0;
    end else begin
      if (strobes.capture) prevMatch <= matchNow;
      flags <= (flags & ~strobes.clrFlag) | strobes.setFlag;
    end
  end
endmodule

// File: rtl/alarm_match_ctl.sv
module alarm_match_ctl
  import alarm_match_pkg::*;
(
  input  logic                  tick,
  input  logic                  clrWe,
  input  logic [NUM_ALARMS-1:0] clrMask,
  input  logic [NUM_ALARMS-1:0] enterMatch,
  output strobe_t               strobes
);
  always_comb begin
    strobes.capture = tick;
    strobes.setFlag = tick ? enterMatch : '0;
    // a new event outranks a clear of the same flag
    strobes.clrFlag = (clrWe ? clrMask : '0) & ~strobes.setFlag;
  end
endmodule

// File: rtl/alarm_match_top.sv
module alarm_match_top
  import alarm_match_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  tick,
  input  logic [TIME_W-1:0]     timeNow,
  input  logic [TIME_W-1:0]     alarm0Val,
  input  logic [NUM_FIELDS-1:0] alarm0En,
  input  logic [TIME_W-1:0]     alarm1Val,
  input  logic [NUM_FIELDS-1:0] alarm1En,
  input  logic                  clrWe,
  input  logic [NUM_ALARMS-1:0] clrMask,
  output logic [NUM_ALARMS-1:0] alarmFlag
);
  strobe_t               strobes;
  logic [NUM_ALARMS-1:0] enterMatch;

  alarm_match_ctl uCtl (
    .tick(tick), .clrWe(clrWe), .clrMask(clrMask),
    .enterMatch(enterMatch), .strobes(strobes)
  );

  alarm_match_dp uDp (
    .clk(clk), .rstN(rstN), .timeNow(timeNow),
    .alarmVal({alarm1Val, alarm0Val}),
    .alarmEn({alarm1En, alarm0En}),
    .strobes(strobes), .enterMatch(enterMatch), .flags(alarmFlag)
  );
endmodule

// File: rtl/alarm_match_chk.sv
module alarm_match_chk
  import alarm_match_pkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic                  tick,
  input logic [NUM_FIELDS-1:0] alarm0En,
  input logic [NUM_FIELDS-1:0] alarm1En,
  input logic                  clrWe,
  input logic [NUM_ALARMS-1:0] clrMask,
  input logic [NUM_ALARMS-1:0] alarmFlag
);
  AST_RESET_CLEAR: assert property (@(posedge clk) !rstN |=> alarmFlag == '0); // R1
  AST_SET_ONLY_ON_TICK0: assert property (@(posedge clk) disable iff (!rstN)
    !tick && !alarmFlag[0] |=> !alarmFlag[0]); // R5
  AST_SET_ONLY_ON_TICK1: assert property (@(posedge clk) disable iff (!rstN)
    !tick && !alarmFlag[1] |=> !alarmFlag[1]); // R5
  AST_EMPTY_SILENT0: assert property (@(posedge clk) disable iff (!rstN)
    alarm0En == '0 && !alarmFlag[0] |=> !alarmFlag[0]); // R4
  AST_EMPTY_SILENT1: assert property (@(posedge clk) disable iff (!rstN)
    alarm1En == '0 && !alarmFlag[1] |=> !alarmFlag[1]); // R4
  AST_STICKY0: assert property (@(posedge clk) disable iff (!rstN)
    alarmFlag[0] && !(clrWe && clrMask[0]) |=> alarmFlag[0]); // R6
  AST_STICKY1: assert property (@(posedge clk) disable iff (!rstN)
    alarmFlag[1] && !(clrWe && clrMask[1]) |=> alarmFlag[1]); // R6
  AST_CLEAR_IDLE0: assert property (@(posedge clk) disable iff (!rstN)
    clrWe && clrMask[0] && !tick |=> !alarmFlag[0]); // R7
  AST_CLEAR_IDLE1: assert property (@(posedge clk) disable iff (!rstN)
    clrWe && clrMask[1] && !tick |=> !alarmFlag[1]); // R7
endmodule

bind alarm_match_top alarm_match_chk uChk (
  .clk(clk), .rstN(rstN), .tick(tick), .alarm0En(alarm0En),
  .alarm1En(alarm1En), .clrWe(clrWe), .clrMask(clrMask), .alarmFlag(alarmFlag)
);

// File: tb/alarm_match_top_test.sv
`timescale 1ns/1ps
module alarm_match_top_test;
  logic        clk = 0;
  logic        rstN = 0;
  logic        tick = 0;
  logic [55:0] timeNow = '0;
  logic [55:0] alarm0Val = '0, alarm1Val = '0;
  logic [6:0]  alarm0En = '0, alarm1En = '0;
  logic        clrWe = 0;
  logic [1:0]  clrMask = '0;
  logic [1:0]  alarmFlag;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [1:0] expFlag = '0, expPrev = '0;

  alarm_match_top uut (
    .clk(clk), .rstN(rstN), .tick(tick), .timeNow(timeNow),
    .alarm0Val(alarm0Val), .alarm0En(alarm0En),
    .alarm1Val(alarm1Val), .alarm1En(alarm1En),
    .clrWe(clrWe), .clrMask(clrMask), .alarmFlag(alarmFlag)
  );

  always #10 clk = ~clk;

  function automatic bit modelMatch(logic [55:0] t, logic [55:0] v, logic [6:0] en);
    bit ok = (en != 0);
    for (int f = 0; f < 7; f++) begin
      logic [7:0] m = (f == 2) ? 8'h7F : 8'hFF;
      if (en[f] && ((t[f*8 +: 8] & m) != (v[f*8 +: 8] & m))) ok = 0;
    end
    return ok;
  endfunction

  task automatic check(string tag);
    checks++;
    if (alarmFlag !== expFlag) begin
      errors++;
      $display("FAIL %s: alarmFlag=%b expected=%b", tag, alarmFlag, expFlag);
    end
  endtask

  // one cycle: drive at negedge, model, sample after the edge
  task automatic step(bit tk, bit cw, logic [1:0] cm, string tag);
    logic [1:0] m, hit, clr;
    @(negedge clk);
    tick = tk; clrWe = cw; clrMask = cm;
    m = {modelMatch(timeNow, alarm1Val, alarm1En), modelMatch(timeNow, alarm0Val, alarm0En)};
    hit = tk ? (m & ~expPrev) : 2'b00;
    if (tk) expPrev = m;
    clr = cw ? cm : 2'b00;
    expFlag = (expFlag & ~clr) | hit;
    @(posedge clk); #1;
    check(tag);
    tick = 0; clrWe = 0; clrMask = 0;
  endtask

  function automatic logic [55:0] mkTime(logic [7:0] wd, logic [7:0] yr, logic [7:0] mo,
      logic [7:0] dt, logic [7:0] hr, logic [7:0] mn, logic [7:0] sc);
    return {wd, yr, mo, dt, hr, mn, sc};
  endfunction

  initial begin
    #3000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: expired, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(posedge clk);
    #1; check("R1 reset");
    @(negedge clk); rstN = 1;
    step(0, 0, 0, "R1 idle after reset");

    // R4: empty enables never fire even when values equal
    timeNow = mkTime(8'h03, 8'h24, 8'h06, 8'h15, 8'h08, 8'h00, 8'h00);
    alarm0Val = timeNow; alarm0En = 0;
    step(1, 0, 0, "R4 empty alarm");

    // R2 daily: hour+minute, other bytes differ
    alarm0Val = mkTime(8'h05, 8'h99, 8'h12, 8'h31, 8'h21, 8'h30, 8'h45);
    alarm0En = 7'b0000110;
    timeNow = mkTime(8'h01, 8'h24, 8'h02, 8'h07, 8'h21, 8'h30, 8'h10);
    step(0, 0, 0, "R5 match without tick");
    step(1, 0, 0, "R2 daily alarm sets");
    step(1, 0, 0, "R9 other alarm untouched");
    // R6: clear during persisting match, no re-set
    step(0, 1, 2'b01, "R7 clear");
    timeNow[7:0] = 8'h11;
    step(1, 0, 0, "R6 no reset while match persists");
    // R2 weekly: weekday mismatch blocks
    alarm0En = 7'b1000110;
    timeNow = mkTime(8'h02, 8'h24, 8'h02, 8'h07, 8'h08, 8'h00, 8'h00);
    alarm0Val = mkTime(8'h03, 8'h00, 8'h00, 8'h00, 8'h08, 8'h00, 8'h00);
    step(1, 0, 0, "R2 weekly wrong day");
    timeNow[55:48] = 8'h03;
    step(1, 0, 0, "R2 weekly right day");
    // R3: hour bit 7 ignored, alarm1 hour only
    alarm1Val = mkTime(0, 0, 0, 0, 8'h08, 0, 0);
    alarm1En = 7'b0000100;
    timeNow[23:16] = 8'h88;
    step(1, 0, 0, "R3 mode bit ignored");
    // R7 mask 0 leaves flags
    step(0, 1, 2'b00, "R7 zero mask");
    step(0, 1, 2'b10, "R9 clear one only");
    // R8 simultaneous: leave then re-enter with clear
    timeNow[23:16] = 8'h09;
    step(1, 0, 0, "R6 leave match");
    timeNow[23:16] = 8'h08;
    step(1, 1, 2'b10, "R8 set beats clear");
    // R2 yearly
    alarm1Val = mkTime(0, 0, 8'h06, 8'h15, 8'h12, 8'h00, 8'h00);
    alarm1En = 7'b0011111;
    timeNow = mkTime(8'h04, 8'h25, 8'h06, 8'h15, 8'h12, 8'h00, 8'h00);
    step(0, 1, 2'b11, "R7 clear both");
    step(1, 0, 0, "R2 yearly sets");

    // random: narrow byte range gives frequent matches
    for (int n = 0; n < 3000; n++) begin
      for (int f = 0; f < 7; f++) begin
        timeNow[f*8 +: 8] = 8'($urandom_range(0, 1)) | (8'($urandom_range(0, 1)) << 7);
        if (($urandom & 15) == 0) begin
          alarm0Val[f*8 +: 8] = 8'($urandom_range(0, 1));
          alarm1Val[f*8 +: 8] = 8'($urandom_range(0, 1)) | 8'h80;
        end
      end
      if (($urandom & 31) == 0) begin
        alarm0En = 7'($urandom) & 7'($urandom);
        alarm1En = 7'($urandom) & 7'($urandom);
      end
      step(($urandom & 1) == 1, ($urandom & 7) == 0, 2'($urandom), "R6 random");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule